// File: doc/BRIEF.md
# Row Reactivation Timer Table

This block lives inside a DRAM memory controller. It keeps track of how long ago each recently used DRAM row was closed, and uses that age to choose the latency mode for the next activation of the same row. A row that is reopened very soon after it was closed still holds plenty of charge. It may be activated with shortened activation timing and closed again with only partial charge restoration. A row reopened a little later may still be closed with partial restoration, but it needs normal activation timing. Any other row gets full timing.

The table is set-associative. Each way holds a row tag, a down-counting timer, a flag recording that the row was last closed with partial restoration, and a valid bit. A free-running 1 ms strobe ages every timer. A row that was left partially restored must not outlive its safety window. So when such an entry's timer runs out, or when the entry is evicted to make room, the block queues a corrective full-restore request (an activate/precharge pair) for that row. The scheduler drains the queue through a valid/ready handshake. The timer reload value is a parameter, so the partial-restore window can be scaled down when a shorter refresh interval is in use.

The controller presents the row address on the activation port when it opens a row and reads back the chosen mode one cycle later. It presents the row on the precharge port when it closes the row, together with a flag that says whether that close used partial restoration.

Top module: `row_reactivation_table`

## Requirements
- R1: After reset every way is empty, `mode_valid` and `rq_valid` are low, and any lookup returns full timing.
- R2: An activation whose row hits an entry whose timer still equals the reload value (default 15) returns mode 2 (partial restore with reduced activation).
- R3: An activation whose row hits an entry whose timer is between 1 and reload-1 returns mode 1 (partial restore only).
- R4: An activation that misses, or that hits an entry whose timer reads 0, returns mode 0 (full timing). The mode is valid exactly one cycle after `act_valid`.
- R5: A precharge of a row with no entry allocates one with the timer at the reload value and the partial flag cleared. Such an entry expires without producing a restore request.
- R6: A precharge that hits reloads the timer to the reload value, sets the partial flag from `pre_partial`, and makes the way most recently used.
- R7: Each `tick_1ms` pulse decrements every valid nonzero timer by one. An activation in the same cycle as the tick sees the value from before the decrement.
- R8: An entry whose timer has reached 0 is invalidated. If its partial flag was set, a restore request for its full row address is queued. The set index is the low bits of the row address.
- R9: A miss precharge into a full set replaces the least recently precharged way. If that way's partial flag was set, a restore request for the evicted row is queued.
- R10: Queued restore requests leave in arrival order. While `rq_ready` is low, `rq_valid` stays high and `rq_row` stays unchanged.
- R11: When the request queue is full and a miss precharge would evict a partially restored way, the precharge is ignored. The victim keeps its entry and the new row stays untracked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| act_valid | input | 1 | A row is being activated |
| act_row | input | ROW_W | Row address being activated |
| mode_valid | output | 1 | Mode for the previous cycle's activation is valid |
| mode | output | 2 | 0 full timing, 1 partial restore, 2 partial restore with reduced activation |
| pre_valid | input | 1 | A row is being precharged |
| pre_row | input | ROW_W | Row address being precharged |
| pre_partial | input | 1 | The close used partial restoration |
| rq_valid | output | 1 | A full-restore request is pending |
| rq_ready | input | 1 | Scheduler accepts the pending request |
| rq_row | output | ROW_W | Row that needs an activate/precharge pair |

## Verification
Some properties are checked on every cycle: timers only count down by one on a tick, the LRU ages in each set always have exactly one oldest way, the request queue is never pushed while full, and a held request stays stable. A freshly allocated way is checked to start with a clear partial flag and a full timer. Other behaviour can only be shown by the bench's scenarios. That covers the mode chosen for a given history of precharges and ticks, the mode when a lookup and a tick fall in the same cycle, and which way LRU picks as the victim. It also covers the order in which expiry and eviction requests leave the queue, and whether a blocked precharge really left the set untouched.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

    typedef enum logic [1:0] {
        MODE_FULL    = 2'd0,
        MODE_PR      = 2'd1,
        MODE_PR_FAST = 2'd2
    } rrt_mode_e;

    function automatic rrt_mode_e rrt_pick_mode(input logic hit,
                                                input logic fresh,
                                                input logic expired);
        if (!hit || expired) return MODE_FULL;
        if (fresh)           return MODE_PR_FAST;
        return MODE_PR;
    endfunction

endpackage

// File: rtl/rrt_set.sv
module rrt_set #(
    parameter int WAYS     = 8,
    parameter int TAG_W    = 11,
    parameter int TMR_W    = 4,
    parameter int TMR_LOAD = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [TAG_W-1:0] act_tag,
    output logic             act_hit,
    output logic [TMR_W-1:0] act_tmr,
    input  logic             pre_en,
    input  logic [TAG_W-1:0] pre_tag,
    input  logic             pre_partial,
    input  logic             push_ok,
    output logic             needs_push,
    output logic [TAG_W-1:0] victim_tag,
    input  logic             sweep_en,
    output logic             exp_any,
    output logic             exp_pr,
    output logic [TAG_W-1:0] exp_tag
);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [WAYS-1:0]  valid_q, pr_q;
    logic [TAG_W-1:0] tag_q [WAYS];
    logic [TMR_W-1:0] tmr_q [WAYS];
    logic [WAY_W-1:0] age_q [WAYS];

    logic             pre_hit, inv_found, pre_write;
    logic [WAY_W-1:0] hit_way, victim, tgt, tgt_age, exp_way;
    logic [WAYS-1:0]  oldest_vec;

    // activation lookup
    always_comb begin
        act_hit = 1'b0;
        act_tmr = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (valid_q[i] && tag_q[i] == act_tag) begin
                act_hit = 1'b1;
                act_tmr = tmr_q[i];
            end
        end
    end

    // precharge lookup and victim choice
    always_comb begin
        pre_hit = 1'b0;
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (valid_q[i] && tag_q[i] == pre_tag) begin
                pre_hit = 1'b1;
                hit_way = WAY_W'(i);
            end
        end
        inv_found = 1'b0;
        victim    = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                inv_found = 1'b1;
                victim    = WAY_W'(i);
            end
        end
        for (int i = 0; i < WAYS; i++) begin
            oldest_vec[i] = (age_q[i] == WAY_W'(WAYS - 1));
            if (!inv_found && oldest_vec[i]) victim = WAY_W'(i);
        end
    end

    assign tgt        = pre_hit ? hit_way : victim;
    assign tgt_age    = age_q[tgt];
    assign needs_push = !pre_hit && valid_q[victim] && pr_q[victim];
    assign victim_tag = tag_q[victim];
    assign pre_write  = pre_en && (!needs_push || push_ok);

    // lowest expired way
    always_comb begin
        exp_any = 1'b0;
        exp_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (valid_q[i] && tmr_q[i] == '0) begin
                exp_any = 1'b1;
                exp_way = WAY_W'(i);
            end
        end
    end
    assign exp_pr  = pr_q[exp_way];
    assign exp_tag = tag_q[exp_way];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WAYS; i++) begin
                valid_q[i] <= 1'b0;
                pr_q[i]    <= 1'b0;
                tag_q[i]   <= '0;
                tmr_q[i]   <= '0;
                age_q[i]   <= WAY_W'(i);
            end
        end else begin
            for (int i = 0; i < WAYS; i++) begin
                if (pre_write && tgt == WAY_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    tag_q[i]   <= pre_tag;
                    tmr_q[i]   <= TMR_W'(TMR_LOAD);
                    pr_q[i]    <= pre_hit ? pre_partial : 1'b0;
                end else if (sweep_en && exp_way == WAY_W'(i)) begin
                    valid_q[i] <= 1'b0;
                    pr_q[i]    <= 1'b0;
                end else if (tick && valid_q[i] && tmr_q[i] != '0) begin
                    tmr_q[i] <= tmr_q[i] - TMR_W'(1);
                end
                if (pre_write) begin
                    if (tgt == WAY_W'(i))       age_q[i] <= '0;
                    else if (age_q[i] < tgt_age) age_q[i] <= age_q[i] + WAY_W'(1);
                end
            end
        end
    end

    // R9: ages stay a permutation, so exactly one way is oldest
    a_r9_single_oldest: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec) == 1);

    for (genvar w = 0; w < WAYS; w++) begin : g_way_chk
        // R7: an untouched nonzero timer drops by exactly one per tick
        a_r7_tick_decrement: assert property (@(posedge clk) disable iff (rst)
            (tick && !pre_en && valid_q[w] && tmr_q[w] != '0)
            |=> (valid_q[w] && tmr_q[w] == $past(tmr_q[w]) - TMR_W'(1)));
        // R5: fresh allocation starts full with a clear partial flag
        a_r5_alloc_state: assert property (@(posedge clk) disable iff (rst)
            (pre_write && !pre_hit && victim == WAY_W'(w))
            |=> (valid_q[w] && !pr_q[w] && tmr_q[w] == TMR_W'(TMR_LOAD)));
        // R2: a valid timer never exceeds the reload value
        a_r2_tmr_bound: assert property (@(posedge clk) disable iff (rst)
            valid_q[w] |-> (tmr_q[w] <= TMR_W'(TMR_LOAD)));
    end

endmodule

// File: rtl/rrt_sweep.sv
module rrt_sweep #(
    parameter int SETS  = 32,
    parameter int TAG_W = 11
) (
    input  logic                        stall,
    input  logic                        fifo_full,
    input  logic [SETS-1:0]             exp_any,
    input  logic [SETS-1:0]             exp_pr,
    input  logic [SETS-1:0][TAG_W-1:0]  exp_tag,
    output logic [SETS-1:0]             sweep_en,
    output logic                        push,
    output logic [TAG_W+$clog2(SETS)-1:0] push_row
);
    localparam int SET_W = $clog2(SETS);

    logic             found, fire;
    logic [SET_W-1:0] sel;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int s = SETS - 1; s >= 0; s--) begin
            if (exp_any[s]) begin
                found = 1'b1;
                sel   = SET_W'(s);
            end
        end
    end

    assign fire     = !stall && found && (!exp_pr[sel] || !fifo_full);
    assign push     = fire && exp_pr[sel];
    assign push_row = {exp_tag[sel], sel};

    always_comb begin
        sweep_en = '0;
        if (fire) sweep_en[sel] = 1'b1;
    end

endmodule

// File: rtl/rrt_req_fifo.sv
module rrt_req_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_pop;

    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign full      = (count == CNT_W'(DEPTH));
    assign do_pop    = pop && out_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push && !full) begin
                mem[wr_ptr] <= push_data;
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            if ((push && !full) && !do_pop)      count <= count + CNT_W'(1);
            else if (!(push && !full) && do_pop) count <= count - CNT_W'(1);
        end
    end

    // R11: upstream never offers a request the queue cannot take
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R10: a stalled head stays put
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !pop) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/row_reactivation_table.sv
module row_reactivation_table #(
    parameter int ROW_W      = 16,
    parameter int SETS       = 32,
    parameter int WAYS       = 8,
    parameter int TMR_W      = 4,
    parameter int TMR_LOAD   = 15,
    parameter int FIFO_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_1ms,
    input  logic             act_valid,
    input  logic [ROW_W-1:0] act_row,
    output logic             mode_valid,
    output logic [1:0]       mode,
    input  logic             pre_valid,
    input  logic [ROW_W-1:0] pre_row,
    input  logic             pre_partial,
    output logic             rq_valid,
    input  logic             rq_ready,
    output logic [ROW_W-1:0] rq_row
);
    import rrt_pkg::*;

    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ROW_W - SET_W;

    logic [SET_W-1:0] act_set, pre_set;
    logic [TAG_W-1:0] act_tag, pre_tag;
    assign act_set = act_row[SET_W-1:0];
    assign act_tag = act_row[ROW_W-1:SET_W];
    assign pre_set = pre_row[SET_W-1:0];
    assign pre_tag = pre_row[ROW_W-1:SET_W];

    logic [SETS-1:0]             act_hit_v, needs_push_v, exp_any_v, exp_pr_v, sweep_en_v;
    logic [SETS-1:0][TMR_W-1:0]  act_tmr_v;
    logic [SETS-1:0][TAG_W-1:0]  victim_tag_v, exp_tag_v;

    logic             fifo_full, evict_push, sw_push, fifo_push;
    logic [ROW_W-1:0] sw_row, fifo_data;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        rrt_set #(
            .WAYS(WAYS), .TAG_W(TAG_W), .TMR_W(TMR_W), .TMR_LOAD(TMR_LOAD)
        ) u_set (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick_1ms),
            .act_tag    (act_tag),
            .act_hit    (act_hit_v[s]),
            .act_tmr    (act_tmr_v[s]),
            .pre_en     (pre_valid && pre_set == SET_W'(s)),
            .pre_tag    (pre_tag),
            .pre_partial(pre_partial),
            .push_ok    (!fifo_full),
            .needs_push (needs_push_v[s]),
            .victim_tag (victim_tag_v[s]),
            .sweep_en   (sweep_en_v[s]),
            .exp_any    (exp_any_v[s]),
            .exp_pr     (exp_pr_v[s]),
            .exp_tag    (exp_tag_v[s])
        );
    end

    rrt_sweep #(.SETS(SETS), .TAG_W(TAG_W)) u_sweep (
        .stall    (pre_valid),
        .fifo_full(fifo_full),
        .exp_any  (exp_any_v),
        .exp_pr   (exp_pr_v),
        .exp_tag  (exp_tag_v),
        .sweep_en (sweep_en_v),
        .push     (sw_push),
        .push_row (sw_row)
    );

    assign evict_push = pre_valid && needs_push_v[pre_set] && !fifo_full;
    assign fifo_push  = evict_push || sw_push;
    assign fifo_data  = evict_push ? {victim_tag_v[pre_set], pre_set} : sw_row;

    rrt_req_fifo #(.DEPTH(FIFO_DEPTH), .W(ROW_W)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (fifo_push),
        .push_data(fifo_data),
        .pop      (rq_ready),
        .out_valid(rq_valid),
        .out_data (rq_row),
        .full     (fifo_full)
    );

    rrt_mode_e mode_q;
    logic      mode_valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_valid_q <= 1'b0;
            mode_q       <= MODE_FULL;
        end else begin
            mode_valid_q <= act_valid;
            mode_q <= rrt_pick_mode(act_hit_v[act_set],
                                    act_tmr_v[act_set] == TMR_W'(TMR_LOAD),
                                    act_tmr_v[act_set] == '0);
        end
    end

    assign mode_valid = mode_valid_q;
    assign mode       = mode_q;

    // R4: mode is reported exactly one cycle after each activation
    a_r4_mode_follows: assert property (@(posedge clk) disable iff (rst)
        act_valid |=> mode_valid);
    a_r4_mode_quiet: assert property (@(posedge clk) disable iff (rst)
        !act_valid |=> !mode_valid);
    // R8: eviction and expiry never compete for the queue in one cycle
    a_r8_single_push: assert property (@(posedge clk) disable iff (rst)
        !(evict_push && sw_push));

endmodule

// File: tb/row_reactivation_table_test.sv
module row_reactivation_table_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1ms = 1'b0;
    logic        act_valid = 1'b0;
    logic [15:0] act_row = '0;
    logic        mode_valid;
    logic [1:0]  mode;
    logic        pre_valid = 1'b0;
    logic [15:0] pre_row = '0;
    logic        pre_partial = 1'b0;
    logic        rq_valid;
    logic        rq_ready = 1'b0;
    logic [15:0] rq_row;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    row_reactivation_table uut (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms),
        .act_valid(act_valid), .act_row(act_row),
        .mode_valid(mode_valid), .mode(mode),
        .pre_valid(pre_valid), .pre_row(pre_row), .pre_partial(pre_partial),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_row(rq_row)
    );

    localparam logic [1:0] OP_ACT = 2'd0, OP_PRE = 2'd1, OP_TICK = 2'd2;
    localparam logic [1:0] M_FULL = 2'd0, M_PR = 2'd1, M_FAST = 2'd2;
    localparam int NVEC = 11;
    // {op, row, partial, expected mode}
    localparam logic [20:0] VEC [NVEC] = '{
        {OP_ACT,  16'h0041, 1'b0, M_FULL},   // R1/R4 miss after reset
        {OP_PRE,  16'h0041, 1'b0, M_FULL},   // R5 allocate
        {OP_ACT,  16'h0041, 1'b0, M_FAST},   // R2
        {OP_TICK, 16'h0000, 1'b0, M_FULL},
        {OP_ACT,  16'h0041, 1'b0, M_PR},     // R3
        {OP_PRE,  16'h0041, 1'b1, M_FULL},   // R6 reload, partial
        {OP_ACT,  16'h0041, 1'b0, M_FAST},   // R6
        {OP_ACT,  16'h0061, 1'b0, M_FULL},   // R4 same set, other tag
        {OP_PRE,  16'h0061, 1'b0, M_FULL},
        {OP_TICK, 16'h0000, 1'b0, M_FULL},
        {OP_ACT,  16'h0061, 1'b0, M_PR}      // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_pre(input logic [15:0] row, input logic partial);
        pre_valid = 1'b1; pre_row = row; pre_partial = partial;
        @(negedge clk);
        pre_valid = 1'b0; pre_partial = 1'b0;
    endtask

    task automatic do_tick();
        tick_1ms = 1'b1;
        @(negedge clk);
        tick_1ms = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_act(input string req, input logic [15:0] row, input logic [1:0] exp);
        act_valid = 1'b1; act_row = row;
        @(negedge clk);
        act_valid = 1'b0;
        tick_1ms  = 1'b0;
        chk({req, " mode_valid"}, {31'd0, mode_valid}, 32'd1);
        chk({req, " mode"}, {30'd0, mode}, {30'd0, exp});
    endtask

    task automatic do_pop(input string req, input logic [15:0] exp_row);
        chk({req, " rq_valid"}, {31'd0, rq_valid}, 32'd1);
        chk({req, " rq_row"}, {16'd0, rq_row}, {16'd0, exp_row});
        rq_ready = 1'b1;
        @(negedge clk);
        rq_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mode_valid after reset", {31'd0, mode_valid}, 32'd0);
        chk("R1 rq_valid after reset", {31'd0, rq_valid}, 32'd0);

        // vector walk
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][20:19])
                OP_ACT:  do_act($sformatf("R2/R3/R4 vec%0d", i), VEC[i][18:3], VEC[i][1:0]);
                OP_PRE:  do_pre(VEC[i][18:3], VEC[i][2]);
                default: do_tick();
            endcase
        end

        // R8 / R5: both set-1 rows now read 14; run them out
        for (int t = 0; t < 14; t++) do_tick();
        repeat (4) @(negedge clk);
        do_pop("R8 expiry restore", 16'h0041);
        repeat (3) @(negedge clk);
        chk("R5 no restore for unflagged expiry", {31'd0, rq_valid}, 32'd0);
        do_act("R8 expired entry invalidated", 16'h0041, M_FULL);
        do_act("R8 unflagged entry invalidated", 16'h0061, M_FULL);

        // R7: lookup coinciding with tick sees pre-decrement timer
        do_pre(16'h0005, 1'b0);
        tick_1ms = 1'b1;
        do_act("R7 lookup with tick", 16'h0005, M_FAST);
        do_act("R7 after tick", 16'h0005, M_PR);

        // R9: eviction in set 3
        for (int t = 0; t < 8; t++) do_pre(16'((t << 5) | 3), 1'b0);
        do_pre(16'h0003, 1'b1);
        for (int t = 1; t < 8; t++) do_pre(16'((t << 5) | 3), 1'b0);
        do_pre(16'((8 << 5) | 3), 1'b0);
        @(negedge clk);
        do_pop("R9 flagged victim restore", 16'h0003);
        do_act("R9 LRU victim gone", 16'h0003, M_FULL);
        do_act("R9 newcomer present", 16'((8 << 5) | 3), M_FAST);
        do_pre(16'((9 << 5) | 3), 1'b0);
        repeat (2) @(negedge clk);
        chk("R9 unflagged victim no restore", {31'd0, rq_valid}, 32'd0);
        do_act("R9 next LRU victim gone", 16'h0023, M_FULL);
        do_act("R9 younger way kept", 16'h0043, M_FAST);

        // R10 / R11: fill the queue from set 7
        for (int t = 0; t < 8; t++) do_pre(16'((t << 5) | 7), 1'b0);
        for (int t = 0; t < 8; t++) do_pre(16'((t << 5) | 7), 1'b1);
        for (int t = 8; t < 12; t++) do_pre(16'((t << 5) | 7), 1'b0);
        do_pre(16'((12 << 5) | 7), 1'b0);
        do_act("R11 blocked row untracked", 16'((12 << 5) | 7), M_FULL);
        do_act("R11 victim kept", 16'((4 << 5) | 7), M_FAST);
        repeat (3) @(negedge clk);
        chk("R10 held head", {16'd0, rq_row}, 32'h0007);
        do_pop("R10 order 0", 16'h0007);
        do_pop("R10 order 1", 16'h0027);
        do_pop("R10 order 2", 16'h0047);
        do_pop("R10 order 3", 16'h0067);
        chk("R10 queue drained", {31'd0, rq_valid}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule